// File: doc/BRIEF.md
# Transport Stream Packet Synchronizer

This block sits behind a transport-stream input port and turns a raw byte stream into framed packets. The port carries its own clock, a valid qualifier and data. The port clock is sampled by the system clock, and a configuration bit chooses which port-clock edge captures the data. A second bit selects the port width. In byte-wide mode every capture delivers one byte. In bit-serial mode every capture delivers one bit, and eight bits are assembled MSB first into a byte.

The byte stream is searched for a programmable sync token. A candidate token becomes a lock only when tokens keep appearing exactly one packet length apart, for a programmable number of packets in a row. Once locked, the block emits every packet whole, with a start marker on the sync byte and an end marker on the last byte. Late or missing tokens are tolerated up to a separate programmable limit. Reaching that limit drops lock and adds one to a lost-lock counter. The packet length, the token and both thresholds are configuration inputs. Typical settings are 188 bytes, 0x47, 9 and 9. The configuration is held static while the block runs.

Top module: `ts_packet_sync`

## Requirements
- R1: After reset, `locked` is 0, `out_valid` is 0 and `lost_count` is 0.
- R2: In byte-wide mode (`cfg_serial`=0), a byte is captured from `ts_data` at each rising edge of `ts_clk` where `ts_valid` is high. Edges with `ts_valid` low capture nothing.
- R3: With `cfg_clk_inv`=1, capture happens on the falling edge of `ts_clk` instead, and the value present at the rising edge is ignored.
- R4: In serial mode (`cfg_serial`=1), each capture takes one bit from `ts_data[0]`, and every eight captured bits form a byte, first bit in the MSB. Any sampled cycle with `ts_valid` low discards a partially assembled byte.
- R5: Lock is declared on the token that completes `cfg_lock_thr` consecutive tokens (counting the first) spaced exactly `cfg_pkt_len` bytes apart. That token is emitted with `out_sop`=1, in the same cycle that `locked` rises.
- R6: While searching, a non-token byte at the expected spacing abandons the candidate. A token byte at any other spacing does not count toward lock.
- R7: While locked, each packet is emitted as `cfg_pkt_len` consecutive output bytes: `out_sop` on the first, `out_eop` on byte `cfg_pkt_len`-1.
- R8: While locked, a packet whose first byte is not the token is still emitted with `out_sop`, as long as fewer than `cfg_drop_thr` consecutive misses have occurred. A correct token clears the miss count.
- R9: The miss that reaches `cfg_drop_thr` consecutive misses clears `locked`, is not emitted, and increments `lost_count` by one. `lost_count` changes at no other time.
- R10: No byte is emitted while `locked` is 0, so no partial packet leaves the block.
- R11: The token value is programmable. With `cfg_token`=0xB8 and a 188-byte length, only 0xB8 bytes act as sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_serial | input | 1 | 1 = bit-serial port on ts_data[0], 0 = byte-wide |
| cfg_clk_inv | input | 1 | 1 = capture on falling port-clock edge |
| cfg_token | input | 8 | Sync token value |
| cfg_pkt_len | input | LEN_W | Packet length in bytes (at least 1) |
| cfg_lock_thr | input | THR_W | Consecutive tokens needed to lock (at least 1) |
| cfg_drop_thr | input | THR_W | Consecutive misses needed to drop lock (at least 1) |
| ts_clk | input | 1 | Port clock, sampled by clk |
| ts_valid | input | 1 | Port data qualifier |
| ts_data | input | 8 | Port data |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| locked | output | 1 | Lock status |
| lost_count | output | CNT_W | Number of lock losses, wrapping |

## Verification
The hardest state to reach from the ports is a locked stream that takes isolated sync misses and recovers without dropping lock. The same stream must also survive false tokens at the wrong spacing while it is still searching. The stimulus builds packets one byte at a time. It places a decoy token inside the first packet length, corrupts single sync bytes between good ones, and inserts invalid port cycles in the middle of a packet. A behavioural model then predicts every emitted byte and marker. Every capture drives a different value on the unused port-clock edge, so a design that samples the wrong edge returns wrong data.

// File: rtl/ts_sync_pkg.sv
// Shared types for the transport stream synchronizer.
package ts_sync_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } sync_state_t;
endpackage

// File: rtl/ts_edge_sample.sv
// Samples the port clock, valid and data into the system clock domain
// and flags the selected capture edge.
// Assumes: the port clock is slower than clk / 2, and data is stable
// for at least one clk cycle around the capture edge.
module ts_edge_sample #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_clk_inv,
    input  logic              ts_clk,
    input  logic              ts_valid,
    input  logic [DATA_W-1:0] ts_data,
    output logic              cap_evt,
    output logic              cap_valid,
    output logic [DATA_W-1:0] cap_data
);
    logic pclk_q;
    logic pclk_d;

    // Register the port signals once, and keep the prior port-clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pclk_q    <= 1'b0;
            pclk_d    <= 1'b0;
            cap_valid <= 1'b0;
            cap_data  <= '0;
        end else begin
            pclk_q    <= ts_clk;
            pclk_d    <= pclk_q;
            cap_valid <= ts_valid;
            cap_data  <= ts_data;
        end
    end

    // Pick the capture edge and qualify it with valid.
    always_comb begin
        if (cfg_clk_inv)
            cap_evt = ~pclk_q & pclk_d & cap_valid;
        else
            cap_evt = pclk_q & ~pclk_d & cap_valid;
    end
endmodule

// File: rtl/ts_byte_assembler.sv
// Turns capture events into a byte stream. In byte-wide mode each
// event is one byte. In serial mode each event is one bit from lane
// SER_LANE, and bits are assembled MSB first into a byte.
// Assumes: cfg_serial is static while running. A sampled cycle with
// valid low restarts the serial bit count.
module ts_byte_assembler #(
    parameter int DATA_W   = 8,
    parameter int SER_LANE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_serial,
    input  logic              cap_evt,
    input  logic              cap_valid,
    input  logic [DATA_W-1:0] cap_data,
    output logic              byte_vld,
    output logic [DATA_W-1:0] byte_data
);
    localparam int BIT_CNT_W = $clog2(DATA_W);

    logic [DATA_W-2:0]    shreg;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic                 ser_bit;

    assign ser_bit = cap_data[SER_LANE];

    // Produce one registered byte per completed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_vld  <= 1'b0;
            byte_data <= '0;
            shreg     <= '0;
            bit_cnt   <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (!cfg_serial) begin
                bit_cnt <= '0;
                if (cap_evt) begin
                    byte_vld  <= 1'b1;
                    byte_data <= cap_data;
                end
            end else if (!cap_valid) begin
                bit_cnt <= '0;
            end else if (cap_evt) begin
                shreg <= {shreg[DATA_W-3:0], ser_bit};
                if (bit_cnt == BIT_CNT_W'(DATA_W - 1)) begin
                    bit_cnt   <= '0;
                    byte_vld  <= 1'b1;
                    byte_data <= {shreg, ser_bit};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ts_lock_tracker.sv
// Searches the byte stream for the sync token at packet spacing,
// holds lock with miss tolerance, and emits framed packets.
// Assumes: cfg_pkt_len, cfg_lock_thr and cfg_drop_thr are at least 1
// and static while running.
module ts_lock_tracker
    import ts_sync_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int THR_W = 4,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] cfg_token,
    input  logic [LEN_W-1:0]  cfg_pkt_len,
    input  logic [THR_W-1:0]  cfg_lock_thr,
    input  logic [THR_W-1:0]  cfg_drop_thr,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              locked,
    output logic [CNT_W-1:0]  lost_count
);
    sync_state_t        state;
    logic               have_cand;
    logic [LEN_W-1:0]   pos;
    logic [LEN_W-1:0]   pos_adv;
    logic [THR_W-1:0]   hits;
    logic [THR_W-1:0]   misses;
    logic [THR_W:0]     hits_inc;
    logic [THR_W:0]     misses_inc;
    logic               is_token;
    logic               at_start;
    logic               at_last;

    // Next position in the packet, and the per-byte decode terms.
    always_comb begin
        at_last    = (pos == cfg_pkt_len - 1'b1);
        at_start   = (pos == '0);
        pos_adv    = at_last ? '0 : pos + 1'b1;
        is_token   = (byte_data == cfg_token);
        hits_inc   = {1'b0, hits} + 1'b1;
        misses_inc = {1'b0, misses} + 1'b1;
    end

    assign locked = (state == ST_LOCK);

    // Hunt/lock state machine with registered packet output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_HUNT;
            have_cand  <= 1'b0;
            pos        <= '0;
            hits       <= '0;
            misses     <= '0;
            lost_count <= '0;
            out_valid  <= 1'b0;
            out_sop    <= 1'b0;
            out_eop    <= 1'b0;
            out_data   <= '0;
        end else begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            if (byte_vld) begin
                out_data <= byte_data;
                if (state == ST_HUNT) begin
                    if (!have_cand) begin
                        if (is_token) begin
                            pos <= (cfg_pkt_len == 1) ? '0 : LEN_W'(1);
                            if (cfg_lock_thr <= 1) begin
                                state     <= ST_LOCK;
                                misses    <= '0;
                                out_valid <= 1'b1;
                                out_sop   <= 1'b1;
                                out_eop   <= (cfg_pkt_len == 1);
                            end else begin
                                have_cand <= 1'b1;
                                hits      <= THR_W'(1);
                            end
                        end
                    end else if (at_start) begin
                        if (is_token) begin
                            pos <= pos_adv;
                            if (hits_inc >= {1'b0, cfg_lock_thr}) begin
                                state     <= ST_LOCK;
                                have_cand <= 1'b0;
                                misses    <= '0;
                                out_valid <= 1'b1;
                                out_sop   <= 1'b1;
                                out_eop   <= at_last;
                            end else begin
                                hits <= hits_inc[THR_W-1:0];
                            end
                        end else begin
                            have_cand <= 1'b0;
                        end
                    end else begin
                        pos <= pos_adv;
                    end
                end else begin
                    if (at_start && !is_token &&
                        misses_inc >= {1'b0, cfg_drop_thr}) begin
                        state      <= ST_HUNT;
                        have_cand  <= 1'b0;
                        pos        <= '0;
                        lost_count <= lost_count + 1'b1;
                    end else begin
                        if (at_start)
                            misses <= is_token ? '0 : misses_inc[THR_W-1:0];
                        pos       <= pos_adv;
                        out_valid <= 1'b1;
                        out_sop   <= at_start;
                        out_eop   <= at_last;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ts_packet_sync_chk.sv
// Property checker for ts_packet_sync, attached by bind below.
module ts_packet_sync_chk #(
    parameter int LEN_W = 8,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       cfg_token,
    input logic [LEN_W-1:0] cfg_pkt_len,
    input logic             out_valid,
    input logic [7:0]       out_data,
    input logic             out_sop,
    input logic             out_eop,
    input logic             locked,
    input logic [CNT_W-1:0] lost_count
);
    logic [LEN_W-1:0] idx;

    // Track the index of the next output byte inside its packet.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (out_valid)
            idx <= out_sop ? LEN_W'(1) : idx + 1'b1;
    end

    a_r5_lock_entry_token: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (out_valid && out_sop && out_data == cfg_token));

    a_r10_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> locked);

    a_r7_sop_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop) |-> out_valid);

    a_r7_eop_at_len: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eop && cfg_pkt_len > 1) |-> (!out_sop && idx == cfg_pkt_len - 1'b1));

    a_r9_lost_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> lost_count == $past(lost_count) + 1'b1);

    a_r9_lost_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(locked) |-> $stable(lost_count));
endmodule

bind ts_packet_sync ts_packet_sync_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_token  (cfg_token),
    .cfg_pkt_len(cfg_pkt_len),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_sop    (out_sop),
    .out_eop    (out_eop),
    .locked     (locked),
    .lost_count (lost_count)
);

// File: rtl/ts_packet_sync.sv
// Transport stream packet synchronizer top: edge sampling, byte
// assembly, then sync search and framed output.
// Assumes: the configuration is static while rst_n is high.
module ts_packet_sync
    import ts_sync_pkg::*;
#(
    parameter int LEN_W    = 8,
    parameter int THR_W    = 4,
    parameter int CNT_W    = 8,
    parameter int SER_LANE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_serial,
    input  logic              cfg_clk_inv,
    input  logic [7:0]        cfg_token,
    input  logic [LEN_W-1:0]  cfg_pkt_len,
    input  logic [THR_W-1:0]  cfg_lock_thr,
    input  logic [THR_W-1:0]  cfg_drop_thr,
    input  logic              ts_clk,
    input  logic              ts_valid,
    input  logic [7:0]        ts_data,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              locked,
    output logic [CNT_W-1:0]  lost_count
);
    logic              cap_evt;
    logic              cap_valid;
    logic [BYTE_W-1:0] cap_data;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_data;

    ts_edge_sample #(.DATA_W(BYTE_W)) u_sample (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_clk_inv(cfg_clk_inv),
        .ts_clk     (ts_clk),
        .ts_valid   (ts_valid),
        .ts_data    (ts_data),
        .cap_evt    (cap_evt),
        .cap_valid  (cap_valid),
        .cap_data   (cap_data)
    );

    ts_byte_assembler #(.DATA_W(BYTE_W), .SER_LANE(SER_LANE)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_serial(cfg_serial),
        .cap_evt   (cap_evt),
        .cap_valid (cap_valid),
        .cap_data  (cap_data),
        .byte_vld  (byte_vld),
        .byte_data (byte_data)
    );

    ts_lock_tracker #(.LEN_W(LEN_W), .THR_W(THR_W), .CNT_W(CNT_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_token   (cfg_token),
        .cfg_pkt_len (cfg_pkt_len),
        .cfg_lock_thr(cfg_lock_thr),
        .cfg_drop_thr(cfg_drop_thr),
        .byte_vld    (byte_vld),
        .byte_data   (byte_data),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_sop     (out_sop),
        .out_eop     (out_eop),
        .locked      (locked),
        .lost_count  (lost_count)
    );
endmodule

// File: tb/ts_packet_sync_tb.sv
module ts_packet_sync_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_serial = 1'b0;
    logic       cfg_clk_inv = 1'b0;
    logic [7:0] cfg_token = 8'h47;
    logic [7:0] cfg_pkt_len = 8'd12;
    logic [3:0] cfg_lock_thr = 4'd3;
    logic [3:0] cfg_drop_thr = 4'd2;
    logic       ts_clk = 1'b0;
    logic       ts_valid = 1'b0;
    logic [7:0] ts_data = 8'h00;
    logic       out_valid, out_sop, out_eop, locked;
    logic [7:0] out_data;
    logic [7:0] lost_count;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string phase = "R1";

    // Behavioural reference state.
    logic [9:0] exp_q[$];
    int m_lock, m_cand, m_pos, m_hits, m_miss, m_lost;

    ts_packet_sync u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_serial(cfg_serial), .cfg_clk_inv(cfg_clk_inv),
        .cfg_token(cfg_token), .cfg_pkt_len(cfg_pkt_len), .cfg_lock_thr(cfg_lock_thr),
        .cfg_drop_thr(cfg_drop_thr), .ts_clk(ts_clk), .ts_valid(ts_valid), .ts_data(ts_data),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
        .locked(locked), .lost_count(lost_count)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic void push_out(input bit sop, input bit eop, input logic [7:0] b);
        exp_q.push_back({sop, eop, b});
    endfunction

    // Reference model of one captured byte.
    function automatic void model_byte(input logic [7:0] b);
        int L;
        L = int'(cfg_pkt_len);
        if (m_lock == 0) begin
            if (m_cand == 0) begin
                if (b == cfg_token) begin
                    m_pos = 1 % L;
                    if (cfg_lock_thr <= 1) begin
                        m_lock = 1; m_miss = 0; push_out(1, L == 1, b);
                    end else begin
                        m_cand = 1; m_hits = 1;
                    end
                end
            end else if (m_pos == 0) begin
                if (b == cfg_token) begin
                    m_hits++;
                    m_pos = 1 % L;
                    if (m_hits >= int'(cfg_lock_thr)) begin
                        m_lock = 1; m_cand = 0; m_miss = 0; push_out(1, L == 1, b);
                    end
                end else begin
                    m_cand = 0;
                end
            end else begin
                m_pos = (m_pos + 1) % L;
            end
        end else begin
            if (m_pos == 0) begin
                if (b == cfg_token) m_miss = 0;
                else begin
                    m_miss++;
                    if (m_miss >= int'(cfg_drop_thr)) begin
                        m_lock = 0; m_cand = 0; m_pos = 0; m_lost++;
                        return;
                    end
                end
                push_out(1, L == 1, b);
            end else begin
                push_out(0, m_pos == L - 1, b);
            end
            m_pos = (m_pos + 1) % L;
        end
    endfunction

    // One port-clock period; r is present at the rising edge, f at the falling edge.
    task automatic drive_edge(input logic [7:0] r, input logic [7:0] f, input logic v);
        @(negedge clk);
        ts_data = r; ts_valid = v; ts_clk = 1'b1;
        repeat (2) @(negedge clk);
        ts_data = f; ts_clk = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_par(input logic [7:0] b, input logic v);
        if (v) model_byte(b);
        if (cfg_clk_inv) drive_edge(~b, b, v);
        else drive_edge(b, ~b, v);
    endtask

    task automatic send_ser(input logic [7:0] b);
        model_byte(b);
        for (int i = 7; i >= 0; i--) begin
            if (cfg_clk_inv) drive_edge({7'h55, ~b[i]}, {7'h2A, b[i]}, 1'b1);
            else drive_edge({7'h55, b[i]}, {7'h2A, ~b[i]}, 1'b1);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        if (cfg_serial) send_ser(b);
        else send_par(b, 1'b1);
    endtask

    task automatic send_pkt(input logic [7:0] first, input int seed);
        logic [7:0] p;
        send_byte(first);
        for (int i = 1; i < int'(cfg_pkt_len); i++) begin
            p = 8'(seed * 7 + i * 13);
            if (p == cfg_token) p = p ^ 8'h01;
            send_byte(p);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ts_clk = 1'b0; ts_valid = 1'b0; ts_data = 8'h00;
        exp_q.delete();
        m_lock = 0; m_cand = 0; m_pos = 0; m_hits = 0; m_miss = 0; m_lost = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_status(input string tag, input int exp_lock, input int exp_lost);
        repeat (6) @(negedge clk);
        check(locked == exp_lock[0], {tag, " locked"}, locked, exp_lock);
        check(int'(lost_count) == exp_lost, {tag, " lost_count"}, lost_count, exp_lost);
        check(exp_q.size() == 0, {tag, " pending outputs"}, exp_q.size(), 0);
    endtask

    // Compare every output byte with the reference on each clock.
    always @(negedge clk) begin
        logic [9:0] e;
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, {phase, "/R10 unexpected output"}, {out_sop, out_eop, out_data}, 0);
            end else begin
                e = exp_q.pop_front();
                check({out_sop, out_eop, out_data} == e, {phase, "/R7 output byte"},
                      {out_sop, out_eop, out_data}, e);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        check(locked == 1'b0, "R1 locked", locked, 0);
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(lost_count == 8'd0, "R1 lost_count", lost_count, 0);

        // R6: decoy token at wrong spacing, candidate abandoned on a miss
        phase = "R6";
        send_par(8'h47, 1'b1);
        for (int i = 0; i < 4; i++) send_par(8'h10 + 8'(i), 1'b1);
        send_par(8'h47, 1'b1);
        for (int i = 0; i < 9; i++) send_par(8'h20 + 8'(i), 1'b1);
        check_status("R6 decoy", 0, 0);

        // R5: lock after the third spaced token
        phase = "R5";
        send_pkt(8'h47, 1);
        send_pkt(8'h47, 2);
        check_status("R5 two tokens", 0, 0);
        send_pkt(8'h47, 3);
        check_status("R5 third token", 1, 0);

        // R8: isolated misses keep lock and packets flow
        phase = "R8";
        send_pkt(8'h47, 4);
        send_pkt(8'h00, 5);
        send_pkt(8'h47, 6);
        send_pkt(8'h3C, 7);
        send_pkt(8'h47, 8);
        check_status("R8 flywheel", 1, 0);

        // R2: invalid port cycles inside a packet are not captured
        phase = "R2";
        send_par(8'h47, 1'b1);
        send_par(8'hAA, 1'b0);
        for (int i = 1; i < 12; i++) begin
            send_par(8'h60 + 8'(i), 1'b1);
            if (i == 5) send_par(8'h47, 1'b0);
        end
        check_status("R2 valid gaps", 1, 0);

        // R9 / R10: two consecutive misses drop lock, then nothing is emitted
        phase = "R9";
        send_pkt(8'h01, 9);
        send_pkt(8'h02, 10);
        check_status("R9 drop", 0, 1);
        phase = "R10";
        send_pkt(8'h47, 11);
        send_pkt(8'h47, 12);
        check_status("R10 hunting quiet", 0, 1);

        // R3: inverted port clock
        phase = "R3";
        cfg_clk_inv = 1'b1; cfg_lock_thr = 4'd2;
        do_reset();
        send_pkt(8'h47, 20);
        send_pkt(8'h47, 21);
        send_pkt(8'h47, 22);
        check_status("R3 falling edge", 1, 0);

        // R4: serial port with a discarded partial byte
        phase = "R4";
        cfg_clk_inv = 1'b0; cfg_serial = 1'b1;
        do_reset();
        for (int i = 0; i < 3; i++) drive_edge(8'h01, 8'h00, 1'b1);
        drive_edge(8'h00, 8'h00, 1'b0);
        send_pkt(8'h47, 30);
        send_pkt(8'h47, 31);
        send_pkt(8'h47, 32);
        check_status("R4 serial", 1, 0);

        // R11: other token value at full packet length and default thresholds
        phase = "R11";
        cfg_serial = 1'b0; cfg_token = 8'hB8; cfg_pkt_len = 8'd188;
        cfg_lock_thr = 4'd9; cfg_drop_thr = 4'd9;
        do_reset();
        for (int k = 0; k < 8; k++) send_pkt(8'hB8, 40 + k);
        check_status("R11 eight tokens", 0, 0);
        send_pkt(8'hB8, 48);
        send_pkt(8'hB8, 49);
        check_status("R11 ninth token", 1, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule